// File: doc/BRIEF.md
# Complementary Half-Bridge PWM Generator

This block drives the two switches of an asymmetric half-bridge. Every switching period starts with the low-side switch. A feedback code, digitized from the control loop, sets how long that switch conducts. The high-side switch conducts for what is left of the period, and a fixed number of idle cycles separates every turn-off from the opposite turn-on. The low-side conduction window never exceeds half the period.

Around that core the generator applies three limits. A soft-start cap holds the low-side window back after each enable and opens it a fixed number of cycles per period. A current-limit flag from an external comparator ends the low-side pulse early, but only after a blanking interval. A hysteretic standby mode stops all switching for whole periods while the feedback code is low.

The period length, the feedback code and the burst state are all taken at period boundaries, so a period is never cut short by a change of input. The protection supervisor drives `en`. Dropping `en` silences both gates in the same cycle and rearms soft-start.

Top module: `hb_pwm_gen`

## Requirements
- R1: While `rst_n` or `en` is low, `gate_hi`, `gate_lo` and `burst_active` are all low. Deasserting `en` clears both gates in that same cycle, without waiting for a clock edge.
- R2: A switching period lasts `period_cfg` cycles. The value is sampled at each period boundary, so a new setting takes effect from the next period.
- R3: With counter position c (0 at period start) and low-side edge E, `gate_lo` is high for DEAD_CYC <= c < E. E is the lesser of the soft-start cap and a feedback term: 0 for `fb_code` <= FB_LO, half the period for `fb_code` >= FB_LO + 2^SPAN_LOG2, and otherwise floor((`fb_code` - FB_LO) * floor(period/2) / 2^SPAN_LOG2).
- R4: E never exceeds floor(period/2), so the low side conducts for at most floor(period/2) - DEAD_CYC cycles per period.
- R5: `gate_hi` is high from c = E + DEAD_CYC to the end of the period. The two gates are never high together, and every rising gate is preceded by at least DEAD_CYC cycles with both gates low.
- R6: If `ilim_flag` is high in a cycle where `gate_lo` is high and c >= DEAD_CYC + BLANK_CYC, then `gate_lo` is low from the next cycle to the end of that period, and `gate_hi` starts DEAD_CYC cycles after that cut. The next period is not affected.
- R7: `ilim_flag` has no effect during the first BLANK_CYC cycles of each low-side pulse (DEAD_CYC <= c < DEAD_CYC + BLANK_CYC).
- R8: The soft-start cap is 0 in the first period after enable. At each boundary it grows by SS_STEP cycles, saturating at half the new period.
- R9: At a period boundary where `fb_code` < FB_BURST_LO, burst mode starts: `burst_active` goes high and both gates stay low for whole periods.
- R10: Burst mode ends only at a boundary where `fb_code` > FB_BURST_HI. For codes from FB_BURST_LO up to FB_BURST_HI inclusive, the present state is kept.
- R11: After `en` is dropped and raised again, soft-start restarts from a cap of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run permission from the protection supervisor |
| period_cfg | input | CNT_W | Switching period in clock cycles |
| fb_code | input | FB_W | Digitized feedback level |
| ilim_flag | input | 1 | Current-sense comparator has reached the cycle limit |
| gate_hi | output | 1 | High-side switch command |
| gate_lo | output | 1 | Low-side switch command |
| burst_active | output | 1 | Standby skipping in force |

## Verification
The assertions check the following on every cycle, at the ports:
- the two gates never overlap;
- the idle gap before every gate rise is at least DEAD_CYC cycles;
- both gates are silent while disabled or in burst;
- each burst entry and exit is consistent with the feedback code at that boundary;
- a current-limit hit after blanking cuts the low-side pulse on the next cycle.

Only the bench scenarios can show the following, because they depend on pulse widths measured over whole periods:
- the exact duty mapping and its clamps;
- the soft-start progression and its restart after re-enable;
- a blanked current-limit flag being ignored;
- a new period length taking effect.

// File: rtl/hb_pwm_pkg.sv
`timescale 1ns/1ps
package hb_pwm_pkg;
  // Where the period counter sits relative to the low-side edge.
  typedef enum logic [1:0] {
    PH_GAP_PRE  = 2'd0,
    PH_LOW_ON   = 2'd1,
    PH_GAP_POST = 2'd2,
    PH_HIGH_ON  = 2'd3
  } hb_phase_e;
endpackage

// File: rtl/hb_period_timer.sv
`timescale 1ns/1ps
module hb_period_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] per_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
  // Boundary: the coming edge closes the present period.
  assign wrap = en && (cnt_inc >= {1'b0, per_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      per_q <= '0;
    end else if (!en) begin
      cnt   <= '0;
      per_q <= period_cfg;
    end else if (wrap) begin
      cnt   <= '0;
      per_q <= period_cfg;
    end else begin
      cnt   <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/hb_duty_map.sv
`timescale 1ns/1ps
module hb_duty_map #(
  parameter int CNT_W     = 12,
  parameter int FB_W      = 10,
  parameter int FB_LO     = 256,
  parameter int SPAN_LOG2 = 9,
  parameter int SS_STEP   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wrap,
  input  logic [FB_W-1:0]  fb_code,
  input  logic [CNT_W-1:0] period_cfg,
  output logic [CNT_W-1:0] edge_target
);
  localparam int             PW     = FB_W + 1 + CNT_W;
  localparam int             FB_TOP = FB_LO + (1 << SPAN_LOG2);
  localparam logic [CNT_W:0] STEP_C = (CNT_W+1)'(SS_STEP);

  logic [CNT_W-1:0] half, ss_q, ss_next, lraw;
  logic [CNT_W:0]   ss_sum;
  logic [FB_W:0]    fb_off;
  logic [PW-1:0]    prod;

  assign half    = period_cfg >> 1;
  assign ss_sum  = {1'b0, ss_q} + STEP_C;
  assign ss_next = (ss_sum >= {1'b0, half}) ? half : ss_sum[CNT_W-1:0];

  // The carrier comparison, expressed as the crossing point of the ramp.
  assign fb_off = {1'b0, fb_code} - (FB_W+1)'(FB_LO);
  assign prod   = PW'(fb_off) * PW'(half);

  always_comb begin
    if (int'(fb_code) <= FB_LO)       lraw = '0;
    else if (int'(fb_code) >= FB_TOP) lraw = half;
    else                              lraw = CNT_W'(prod >> SPAN_LOG2);
  end

  assign edge_target = (lraw < ss_next) ? lraw : ss_next;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) ss_q <= '0;
    else if (wrap)     ss_q <= ss_next;
  end
endmodule

// File: rtl/hb_burst_ctl.sv
`timescale 1ns/1ps
module hb_burst_ctl #(
  parameter int FB_W        = 10,
  parameter int FB_BURST_LO = 333,
  parameter int FB_BURST_HI = 384
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            wrap,
  input  logic [FB_W-1:0] fb_code,
  output logic            burst_q
);
  logic go_quiet, go_live;

  assign go_quiet = int'(fb_code) < FB_BURST_LO;
  assign go_live  = int'(fb_code) > FB_BURST_HI;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)       burst_q <= 1'b0;
    else if (wrap) begin
      if (go_quiet)          burst_q <= 1'b1;
      else if (go_live)      burst_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hb_gate_drive.sv
`timescale 1ns/1ps
module hb_gate_drive
  import hb_pwm_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DEAD_CYC  = 40,
  parameter int BLANK_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wrap,
  input  logic             burst_q,
  input  logic             ilim_flag,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] edge_target,
  output logic             gate_hi,
  output logic             gate_lo
);
  localparam logic [CNT_W:0] DEAD_W = (CNT_W+1)'(DEAD_CYC);
  localparam logic [CNT_W:0] TRIP_W = (CNT_W+1)'(DEAD_CYC + BLANK_CYC);

  logic [CNT_W-1:0] edge_q;
  logic [CNT_W:0]   cnt_w, hi_start;
  hb_phase_e        phase;
  logic             active, trip;

  assign cnt_w    = {1'b0, cnt};
  assign hi_start = {1'b0, edge_q} + DEAD_W;

  always_comb begin
    if (cnt_w >= hi_start)                         phase = PH_HIGH_ON;
    else if (cnt_w >= DEAD_W && cnt < edge_q)      phase = PH_LOW_ON;
    else if (cnt_w < DEAD_W)                       phase = PH_GAP_PRE;
    else                                           phase = PH_GAP_POST;
  end

  assign active  = en && !burst_q;
  assign gate_lo = active && (phase == PH_LOW_ON);
  assign gate_hi = active && (phase == PH_HIGH_ON);
  // A past-blanking limit hit pulls the edge in to the next cycle.
  assign trip    = gate_lo && ilim_flag && (cnt_w >= TRIP_W);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) edge_q <= '0;
    else if (wrap)     edge_q <= edge_target;
    else if (trip)     edge_q <= cnt + 1'b1;
  end
endmodule

// File: rtl/hb_pwm_gen.sv
`timescale 1ns/1ps
module hb_pwm_gen #(
  parameter int CNT_W       = 12,
  parameter int FB_W        = 10,
  parameter int DEAD_CYC    = 40,
  parameter int BLANK_CYC   = 8,
  parameter int SS_STEP     = 1,
  parameter int FB_LO       = 256,
  parameter int SPAN_LOG2   = 9,
  parameter int FB_BURST_LO = 333,
  parameter int FB_BURST_HI = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [FB_W-1:0]  fb_code,
  input  logic             ilim_flag,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             burst_active
);
  logic [CNT_W-1:0] cnt, edge_target;
  logic             wrap, burst_q;

  hb_period_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .en(en), .period_cfg(period_cfg),
    .cnt(cnt), .wrap(wrap)
  );

  hb_duty_map #(
    .CNT_W(CNT_W), .FB_W(FB_W), .FB_LO(FB_LO),
    .SPAN_LOG2(SPAN_LOG2), .SS_STEP(SS_STEP)
  ) duty_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .fb_code(fb_code),
    .period_cfg(period_cfg), .edge_target(edge_target)
  );

  hb_burst_ctl #(
    .FB_W(FB_W), .FB_BURST_LO(FB_BURST_LO), .FB_BURST_HI(FB_BURST_HI)
  ) burst_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .fb_code(fb_code),
    .burst_q(burst_q)
  );

  hb_gate_drive #(
    .CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC)
  ) drive_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .burst_q(burst_q),
    .ilim_flag(ilim_flag), .cnt(cnt), .edge_target(edge_target),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  assign burst_active = burst_q && en;
endmodule

// File: rtl/hb_pwm_gen_chk.sv
`timescale 1ns/1ps
module hb_pwm_gen_chk #(
  parameter int CNT_W       = 12,
  parameter int FB_W        = 10,
  parameter int DEAD_CYC    = 40,
  parameter int BLANK_CYC   = 8,
  parameter int FB_BURST_LO = 333,
  parameter int FB_BURST_HI = 384
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [FB_W-1:0] fb_code,
  input logic            ilim_flag,
  input logic            gate_hi,
  input logic            gate_lo,
  input logic            burst_active
);
  logic [CNT_W-1:0] idle_run, lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run <= '0;
      lo_run   <= '0;
    end else begin
      if (gate_hi || gate_lo)                  idle_run <= '0;
      else if (int'(idle_run) < DEAD_CYC)      idle_run <= idle_run + 1'b1;
      if (!gate_lo)                            lo_run <= '0;
      else if (int'(lo_run) < BLANK_CYC)       lo_run <= lo_run + 1'b1;
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (int'(idle_run) >= DEAD_CYC));

  assert_quiet_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!gate_hi && !gate_lo && !burst_active));

  assert_burst_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> (!gate_hi && !gate_lo));

  assert_burst_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> (int'($past(fb_code)) < FB_BURST_LO));

  assert_burst_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(burst_active) && en && $past(en)) |-> (int'($past(fb_code)) > FB_BURST_HI));

  assert_ilim_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_lo) && $past(ilim_flag) && (int'($past(lo_run)) >= BLANK_CYC)) |-> !gate_lo);
endmodule

bind hb_pwm_gen hb_pwm_gen_chk #(
  .CNT_W(CNT_W), .FB_W(FB_W), .DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC),
  .FB_BURST_LO(FB_BURST_LO), .FB_BURST_HI(FB_BURST_HI)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .fb_code(fb_code), .ilim_flag(ilim_flag),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .burst_active(burst_active)
);

// File: tb/hb_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module hb_pwm_gen_tb_top;
  localparam int CW = 12, FW = 10, DEAD = 40, BLANK = 8, STEP = 10;
  localparam int FBLO = 256, SPAN = 9, BL = 333, BH = 384;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ilim_flag = 1'b0;
  logic [CW-1:0] period_cfg = 12'd200;
  logic [FW-1:0] fb_code = 10'd768;
  logic gate_hi, gate_lo, burst_active;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  hb_pwm_gen #(
    .CNT_W(CW), .FB_W(FW), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .SS_STEP(STEP),
    .FB_LO(FBLO), .SPAN_LOG2(SPAN), .FB_BURST_LO(BL), .FB_BURST_HI(BH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .period_cfg(period_cfg), .fb_code(fb_code),
    .ilim_flag(ilim_flag), .gate_hi(gate_hi), .gate_lo(gate_lo), .burst_active(burst_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: integers following the requirement text.
  int m_cnt = 0, m_per = 0, m_ss = 0, m_edge = 0, m_burst = 0;

  function automatic int ref_feed(input int fb, input int half);
    if (fb <= FBLO) return 0;
    if (fb >= FBLO + (1 << SPAN)) return half;
    return ((fb - FBLO) * half) / (1 << SPAN);
  endfunction

  function automatic int exp_lo();
    return (en && !m_burst && m_cnt >= DEAD && m_cnt < m_edge) ? 1 : 0;
  endfunction

  function automatic int exp_hi();
    return (en && !m_burst && m_cnt >= m_edge + DEAD) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_ss = 0; m_edge = 0; m_burst = 0;
    end else if (!en) begin
      m_cnt = 0; m_per = int'(period_cfg); m_ss = 0; m_edge = 0; m_burst = 0;
    end else if (m_cnt + 1 >= m_per) begin
      int h, nss, fr;
      h   = int'(period_cfg) / 2;
      nss = (m_ss + STEP >= h) ? h : m_ss + STEP;
      fr  = ref_feed(int'(fb_code), h);
      m_edge = (fr < nss) ? fr : nss;
      m_ss   = nss;
      if (int'(fb_code) < BL) m_burst = 1;
      else if (int'(fb_code) > BH) m_burst = 0;
      m_cnt = 0;
      m_per = int'(period_cfg);
    end else begin
      if (exp_lo() == 1 && ilim_flag && m_cnt >= DEAD + BLANK) m_edge = m_cnt + 1;
      m_cnt = m_cnt + 1;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    chk("R3 gate_lo vs model", int'(gate_lo), exp_lo());
    chk("R5 gate_hi vs model", int'(gate_hi), exp_hi());
    chk("R9 burst_active vs model", int'(burst_active), (en && m_burst) ? 1 : 0);
    chk("R5 gates overlap", int'(gate_hi && gate_lo), 0);
  end

  task automatic run_period(input int trip_at, output int lo_w, output int hi_w, output int bu);
    int per;
    while (m_cnt != 0) @(negedge clk);
    per = m_per; lo_w = 0; hi_w = 0; bu = 0;
    for (int k = 0; k < per; k++) begin
      ilim_flag = (k == trip_at);
      #1;
      lo_w += int'(gate_lo);
      hi_w += int'(gate_hi);
      if (k == per / 2) bu = int'(burst_active);
      @(negedge clk);
    end
    ilim_flag = 1'b0;
  endtask

  task automatic period_len(output int len);
    bit prev, seen;
    int n;
    prev = 1'b1; seen = 1'b0; n = 0; len = 0;
    while (1) begin
      @(negedge clk);
      #1;
      if (gate_lo && !prev) begin
        if (seen) begin len = n; break; end
        seen = 1'b1; n = 0;
      end
      n++;
      prev = gate_lo;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int lo, hi, bu, len;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset gate_hi", int'(gate_hi), 0);
    chk("R1 reset gate_lo", int'(gate_lo), 0);
    chk("R1 reset burst_active", int'(burst_active), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 disabled gates", int'(gate_hi || gate_lo), 0);
    @(negedge clk); en = 1'b1;

    // R8: soft-start from zero, cap = 10*(k-1) in period k
    run_period(-1, lo, hi, bu);
    chk("R8 first period lo", lo, 0);
    chk("R8 first period hi", hi, 160);
    for (int i = 0; i < 4; i++) run_period(-1, lo, hi, bu);
    run_period(-1, lo, hi, bu);
    chk("R8 sixth period lo", lo, 10);
    chk("R8 sixth period hi", hi, 110);
    for (int i = 0; i < 5; i++) run_period(-1, lo, hi, bu);
    run_period(-1, lo, hi, bu);
    chk("R3 top clamp lo", lo, 60);
    chk("R3 top clamp hi", hi, 60);

    fb_code = 10'd1023; run_period(-1, lo, hi, bu); run_period(-1, lo, hi, bu);
    chk("R4 max duty lo", lo, 60);
    fb_code = 10'd512; run_period(-1, lo, hi, bu); run_period(-1, lo, hi, bu);
    chk("R3 mid code lo", lo, 10);
    chk("R3 mid code hi", hi, 110);
    fb_code = 10'd340; run_period(-1, lo, hi, bu); run_period(-1, lo, hi, bu);
    chk("R3 edge below dead lo", lo, 0);
    chk("R3 edge below dead hi", hi, 144);
    chk("R10 no entry above low threshold", bu, 0);

    fb_code = 10'd768; run_period(-1, lo, hi, bu);
    run_period(60, lo, hi, bu);
    chk("R6 cut lo", lo, 21);
    chk("R6 cut hi", hi, 99);
    run_period(-1, lo, hi, bu);
    chk("R6 next period restored", lo, 60);
    run_period(44, lo, hi, bu);
    chk("R7 blanked flag ignored", lo, 60);
    run_period(47, lo, hi, bu);
    chk("R7 last blanked cycle ignored", lo, 60);
    run_period(48, lo, hi, bu);
    chk("R7 first live cycle lo", lo, 9);
    chk("R6 first live cycle hi", hi, 111);

    fb_code = 10'd300; run_period(-1, lo, hi, bu); run_period(-1, lo, hi, bu);
    chk("R9 burst flag", bu, 1);
    chk("R9 burst no switching", lo + hi, 0);
    fb_code = 10'd384; run_period(-1, lo, hi, bu); run_period(-1, lo, hi, bu);
    chk("R10 held at upper threshold", bu, 1);
    fb_code = 10'd400; run_period(-1, lo, hi, bu); run_period(-1, lo, hi, bu);
    chk("R10 exit flag", bu, 0);
    chk("R10 exit hi", hi, 132);
    fb_code = 10'd333; run_period(-1, lo, hi, bu); run_period(-1, lo, hi, bu);
    chk("R9 no entry at low threshold", bu, 0);
    chk("R9 no entry hi", hi, 145);

    fb_code = 10'd768; period_cfg = 12'd300;
    for (int i = 0; i < 5; i++) run_period(-1, lo, hi, bu);
    run_period(-1, lo, hi, bu);
    chk("R2 new period lo", lo, 110);
    chk("R2 new period hi", hi, 110);
    period_len(len);
    chk("R2 period length", len, 300);

    while (m_cnt != 50) @(negedge clk);
    en = 1'b0;
    #1;
    chk("R1 immediate gate_lo off", int'(gate_lo), 0);
    chk("R1 immediate gate_hi off", int'(gate_hi), 0);
    repeat (4) @(negedge clk);
    en = 1'b1;
    run_period(-1, lo, hi, bu);
    chk("R11 restart lo", lo, 0);
    chk("R11 restart hi", hi, 260);
    for (int i = 0; i < 4; i++) run_period(-1, lo, hi, bu);
    run_period(-1, lo, hi, bu);
    chk("R11 ramp again lo", lo, 10);
    chk("R11 ramp again hi", hi, 210);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule